// File: doc/BRIEF.md
# Five-Level Rectifier Gate Pattern Generator

This block converts a signed voltage reference into six gate enables for a single-phase five-level rectifier leg arrangement. All switching comes from one internal unipolar triangle carrier. The block splits the reference into three modulating values. A polarity value selects which of the two slow switches conducts for the current grid half-cycle. Two fast values are each compared against the carrier, and each drives one complementary switch pair. Because of the split, a single carrier gives five output levels at a fixed switching frequency.

The carrier amplitude `amp_in` sets both the carrier height and the scale of the reference. A new reference is taken whenever `ref_stb` is high. The modulating values are recomputed only at the carrier's top and bottom turning points, which gives two updates per carrier period. Every complementary pair passes through a dead-band stage with a run-time programmable gap. The block also reports which of the four operating regions the current modulating values belong to.

Top module: `fl5_gate_gen`

## Requirements
- R1: The carrier is a triangle with A = `amp_in`, sampled at each bottom point. After each bottom point it counts 1, 2, … up to A−1, then back down to 0, so a period is 2·(A−1) cycles. For A ≤ 1 the carrier stays at 0.
- R2: `ref_in` is captured only on a cycle with `ref_stb` high. The captured value is used only at the next carrier top or bottom point. A change of `ref_in` without a strobe has no effect on any output.
- R3: Before splitting, the captured reference is clamped to the range −2·A … +2·A.
- R4: For a clamped reference r > 0, polarity is positive. If r < A, the first fast value is r and the second is 0. Otherwise the first is A and the second is r − A.
- R5: For r ≤ 0, polarity is negative. If r < −A, the first fast value is r + 2·A and the second is 0. Otherwise the first is A and the second is r + A.
- R6: Both fast values stay within 0 … A. Their sum, minus 2·A in the negative half-cycle, equals r.
- R7: `region` is set at each carrier turning point: 0 means r > 0 and r < A; 1 means r ≥ A; 2 means r ≤ 0 and r ≥ −A; 3 means r < −A.
- R8: Pair X commands `gate_xa` while the first fast value is strictly greater than the carrier, and `gate_xb` otherwise. Pair Y does the same with the second fast value, using `gate_ya` and `gate_yb`.
- R9: The polarity pair commands `gate_pos` in the positive half-cycle and `gate_neg` in the negative one. The command changes only at a carrier turning point.
- R10: A changed pair command turns both gates of that pair off. The newly commanded gate turns on after exactly `dead_cyc` further cycles; with `dead_cyc` = 0 it turns on at once. The two gates of a pair are never on together.
- R11: Between two carrier turning points, at most one of pair X and pair Y changes its command in any cycle.
- R12: While `rst` is high, all six gates are off and `region` is 0. A gate output changes one cycle after its pair command changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | REF_W | Signed voltage reference, two's complement |
| amp_in | input | AMP_W | Carrier amplitude A, unsigned |
| ref_stb | input | 1 | Capture strobe for `ref_in` |
| dead_cyc | input | DT_W | Dead-band length in clock cycles |
| gate_pos | output | 1 | Positive half-cycle slow switch |
| gate_neg | output | 1 | Negative half-cycle slow switch |
| gate_xa | output | 1 | Pair X, side on while first fast value exceeds carrier |
| gate_xb | output | 1 | Pair X, complementary side |
| gate_ya | output | 1 | Pair Y, side on while second fast value exceeds carrier |
| gate_yb | output | 1 | Pair Y, complementary side |
| region | output | 2 | Operating region code (R7) |

## Verification
The bench holds the reference steady at four points: positive below A, positive above A, negative with magnitude below A, and negative with magnitude above A. These points separate the two branches of each half-cycle split and the four region codes. It then drives the exact boundary values 0, +A, −A and ±2·A, together with far out-of-range values, to check that the comparison edges and the clamp are placed correctly. The remaining tests cover the timing rules. Reference changes are applied without a strobe, then with a strobe on every cycle, to show that only captured values are used and only at turning points. Amplitude steps down to 2 and 1 check the carrier reload, and dead-band lengths of 0, 1, 2 and 7 with a full reference sweep check the gap rule.

// File: rtl/fl5_pkg.sv
package fl5_pkg;

   typedef enum logic [1:0] {
      RG_POS_LO = 2'd0,
      RG_POS_HI = 2'd1,
      RG_NEG_LO = 2'd2,
      RG_NEG_HI = 2'd3
   } region_e;

   localparam int NUM_PAIRS = 3;
   localparam int PAIR_POL  = 0;
   localparam int PAIR_X    = 1;
   localparam int PAIR_Y    = 2;

endpackage

// File: rtl/fl5_carrier.sv
module fl5_carrier #(
   parameter int AMP_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AMP_W-1:0] amp_in,
   output logic [AMP_W-1:0] car,
   output logic [AMP_W-1:0] amp_eff,
   output logic             evt
);

   logic [AMP_W-1:0] c_q, amp_q, top;
   logic             up_q, peak, valley;

   assign top     = (amp_q == '0) ? '0 : amp_q - 1'b1;
   assign peak    = up_q && (c_q >= top);
   assign valley  = !up_q && (c_q == '0);
   assign evt     = peak || valley;
   assign amp_eff = valley ? amp_in : amp_q;
   assign car     = c_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         c_q   <= '0;
         up_q  <= 1'b0;
         amp_q <= '0;
      end else if (up_q) begin
         if (c_q < top) begin
            c_q <= c_q + 1'b1;
         end else begin
            up_q <= 1'b0;
            c_q  <= (c_q == '0) ? '0 : c_q - 1'b1;
         end
      end else begin
         if (c_q != '0) begin
            c_q <= c_q - 1'b1;
         end else begin
            up_q  <= 1'b1;
            amp_q <= amp_in;
            c_q   <= (amp_in > AMP_W'(1)) ? AMP_W'(1) : '0;
         end
      end
   end

   AST_CAR_BOUND: assert property (@(posedge clk) disable iff (rst)
      c_q <= top) else $error("carrier above top");  // R1

   AST_CAR_STEP: assert property (@(posedge clk) disable iff (rst)
      (({1'b0, c_q}) <= ({1'b0, $past(c_q)} + 1'b1)) &&
      (({1'b0, c_q} + 1'b1) >= ({1'b0, $past(c_q)})))
      else $error("carrier jumped");  // R1

endmodule

// File: rtl/fl5_split.sv
module fl5_split #(
   parameter int REF_W = 16,
   parameter int AMP_W = 12
) (
   input  logic signed [REF_W-1:0] ref_v,
   input  logic        [AMP_W-1:0] amp,
   output logic                    pos,
   output logic        [AMP_W-1:0] mod_x,
   output logic        [AMP_W-1:0] mod_y,
   output fl5_pkg::region_e        region
);
   import fl5_pkg::*;

   localparam int WW = REF_W + 2;
   localparam logic signed [WW-1:0] ZERO = '0;

   logic signed [WW-1:0] a_s, a2_s, r_w, r_s, x_w, y_w;

   always_comb begin
      a_s  = $signed({{(WW-AMP_W){1'b0}}, amp});
      a2_s = a_s <<< 1;
      r_w  = {{2{ref_v[REF_W-1]}}, ref_v};
      if (r_w > a2_s)       r_s = a2_s;
      else if (r_w < -a2_s) r_s = -a2_s;
      else                  r_s = r_w;

      if (r_s > ZERO) begin
         pos = 1'b1;
         if (r_s < a_s) begin
            x_w = r_s;  y_w = ZERO;        region = RG_POS_LO;
         end else begin
            x_w = a_s;  y_w = r_s - a_s;   region = RG_POS_HI;
         end
      end else begin
         pos = 1'b0;
         if (r_s < -a_s) begin
            x_w = r_s + a2_s; y_w = ZERO;  region = RG_NEG_HI;
         end else begin
            x_w = a_s;  y_w = r_s + a_s;   region = RG_NEG_LO;
         end
      end
   end

   assign mod_x = x_w[AMP_W-1:0];
   assign mod_y = y_w[AMP_W-1:0];

   always_comb begin
      AST_MOD_RANGE: assert (x_w >= ZERO && x_w <= a_s && y_w >= ZERO && y_w <= a_s)
         else $error("modulating value out of range");  // R6
      AST_SUM_MATCH: assert ((x_w + y_w - (pos ? ZERO : a2_s)) == r_s)
         else $error("split does not rebuild reference");  // R6
   end

endmodule

// File: rtl/fl5_deadband.sv
module fl5_deadband #(
   parameter int DT_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [DT_W-1:0] dead_cyc,
   input  logic            cmd,
   output logic            g_a,
   output logic            g_b
);

   logic            side_q, on_q;
   logic [DT_W-1:0] cnt_q;
   logic [DT_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         side_q <= 1'b0;
         on_q   <= 1'b0;
         cnt_q  <= '0;
      end else if (cmd != side_q) begin
         side_q <= cmd;
         on_q   <= (dead_cyc == '0);
         cnt_q  <= '0;
      end else if (!on_q) begin
         if (cnt_inc >= {1'b0, dead_cyc}) on_q <= 1'b1;
         cnt_q <= cnt_inc[DT_W-1:0];
      end
   end

   assign g_a = on_q & side_q;
   assign g_b = on_q & ~side_q;

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      !(g_a && g_b)) else $error("both gates of a pair on");  // R10

   AST_GAP_A: assert property (@(posedge clk) disable iff (rst)
      ($past(dead_cyc) != '0 && $rose(g_a)) |-> !$past(g_b))
      else $error("no gap before side a");  // R10

   AST_GAP_B: assert property (@(posedge clk) disable iff (rst)
      ($past(dead_cyc) != '0 && $rose(g_b)) |-> !$past(g_a))
      else $error("no gap before side b");  // R10

endmodule

// File: rtl/fl5_gate_gen.sv
module fl5_gate_gen #(
   parameter int REF_W = 16,
   parameter int AMP_W = 12,
   parameter int DT_W  = 6
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic        [AMP_W-1:0] amp_in,
   input  logic                    ref_stb,
   input  logic        [DT_W-1:0]  dead_cyc,
   output logic                    gate_pos,
   output logic                    gate_neg,
   output logic                    gate_xa,
   output logic                    gate_xb,
   output logic                    gate_ya,
   output logic                    gate_yb,
   output logic        [1:0]       region
);
   import fl5_pkg::*;

   if (AMP_W < 2 || AMP_W > REF_W - 2) begin : g_bad_amp_w
      $error("AMP_W must lie in 2 .. REF_W-2");
   end
   if (DT_W < 1) begin : g_bad_dt_w
      $error("DT_W must be at least 1");
   end

   logic signed [REF_W-1:0] ref_q;
   logic [AMP_W-1:0]        car, amp_eff, mx_d, my_d, mx_q, my_q;
   logic                    evt, pos_d, pos_q;
   region_e                 rg_d, rg_q;
   logic [NUM_PAIRS-1:0]    cmd, ga, gb;

   always_ff @(posedge clk) begin
      if (rst)          ref_q <= '0;
      else if (ref_stb) ref_q <= ref_in;
   end

   fl5_carrier #(.AMP_W(AMP_W)) u_car (
      .clk     (clk),
      .rst     (rst),
      .amp_in  (amp_in),
      .car     (car),
      .amp_eff (amp_eff),
      .evt     (evt)
   );

   fl5_split #(.REF_W(REF_W), .AMP_W(AMP_W)) u_split (
      .ref_v  (ref_q),
      .amp    (amp_eff),
      .pos    (pos_d),
      .mod_x  (mx_d),
      .mod_y  (my_d),
      .region (rg_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= 1'b0;
         mx_q  <= '0;
         my_q  <= '0;
         rg_q  <= RG_POS_LO;
      end else if (evt) begin
         pos_q <= pos_d;
         mx_q  <= mx_d;
         my_q  <= my_d;
         rg_q  <= rg_d;
      end
   end

   assign cmd[PAIR_POL] = pos_q;
   assign cmd[PAIR_X]   = mx_q > car;
   assign cmd[PAIR_Y]   = my_q > car;

   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      fl5_deadband #(.DT_W(DT_W)) u_db (
         .clk      (clk),
         .rst      (rst),
         .dead_cyc (dead_cyc),
         .cmd      (cmd[i]),
         .g_a      (ga[i]),
         .g_b      (gb[i])
      );
   end

   assign gate_pos = ga[PAIR_POL];
   assign gate_neg = gb[PAIR_POL];
   assign gate_xa  = ga[PAIR_X];
   assign gate_xb  = gb[PAIR_X];
   assign gate_ya  = ga[PAIR_Y];
   assign gate_yb  = gb[PAIR_Y];
   assign region   = rg_q;

   AST_ONE_PAIR_MOVES: assert property (@(posedge clk) disable iff (rst)
      !$past(evt) |-> ($stable(cmd[PAIR_X]) || $stable(cmd[PAIR_Y])))
      else $error("both carrier pairs moved in one cycle");  // R11

   AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(evt) |-> $stable(rg_q[1]))
      else $error("half-cycle changed away from a turning point");  // R9

endmodule

// File: tb/test_fl5_gate_gen.sv
module test_fl5_gate_gen;
   localparam int REF_W = 16;
   localparam int AMP_W = 12;
   localparam int DT_W  = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic signed [REF_W-1:0] ref_in = '0;
   logic [AMP_W-1:0] amp_in = '0;
   logic ref_stb = 1'b0;
   logic [DT_W-1:0] dead_cyc = '0;
   logic gate_pos, gate_neg, gate_xa, gate_xb, gate_ya, gate_yb;
   logic [1:0] region;

   always #10 clk = ~clk;

   fl5_gate_gen #(.REF_W(REF_W), .AMP_W(AMP_W), .DT_W(DT_W)) i_fl5_gate_gen (
      .clk(clk), .rst(rst), .ref_in(ref_in), .amp_in(amp_in), .ref_stb(ref_stb),
      .dead_cyc(dead_cyc), .gate_pos(gate_pos), .gate_neg(gate_neg),
      .gate_xa(gate_xa), .gate_xb(gate_xb), .gate_ya(gate_ya), .gate_yb(gate_yb),
      .region(region)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R12";
   bit    cmp_en = 0;

   // behavioural reference model
   int m_c, m_up, m_amp, m_ref, m_pos, m_x, m_y, m_rg;
   int m_side[3], m_on[3], m_cnt[3];

   always @(posedge clk) begin : model
      int top, a, r, d;
      int cmd[3];
      bit pk, vl;
      if (rst) begin
         m_c = 0; m_up = 0; m_amp = 0; m_ref = 0;
         m_pos = 0; m_x = 0; m_y = 0; m_rg = 0;
         for (int i = 0; i < 3; i++) begin m_side[i] = 0; m_on[i] = 0; m_cnt[i] = 0; end
      end else begin
         top = (m_amp > 0) ? m_amp - 1 : 0;
         pk  = (m_up != 0) && (m_c >= top);
         vl  = (m_up == 0) && (m_c == 0);
         a   = vl ? int'(amp_in) : m_amp;
         d   = int'(dead_cyc);
         cmd[0] = m_pos;
         cmd[1] = (m_x > m_c) ? 1 : 0;
         cmd[2] = (m_y > m_c) ? 1 : 0;
         for (int i = 0; i < 3; i++) begin
            if (cmd[i] != m_side[i]) begin
               m_side[i] = cmd[i]; m_cnt[i] = 0; m_on[i] = (d == 0) ? 1 : 0;
            end else if (m_on[i] == 0) begin
               m_cnt[i]++;
               if (m_cnt[i] >= d) m_on[i] = 1;
            end
         end
         if (pk || vl) begin
            r = m_ref;
            if (r > 2*a) r = 2*a;
            if (r < -2*a) r = -2*a;
            if (r > 0) begin
               m_pos = 1;
               if (r < a) begin m_x = r; m_y = 0; m_rg = 0; end
               else begin m_x = a; m_y = r - a; m_rg = 1; end
            end else begin
               m_pos = 0;
               if (r < -a) begin m_x = r + 2*a; m_y = 0; m_rg = 3; end
               else begin m_x = a; m_y = r + a; m_rg = 2; end
            end
         end
         if (m_up != 0) begin
            if (m_c < top) m_c++;
            else begin m_up = 0; m_c = (m_c > 0) ? m_c - 1 : 0; end
         end else begin
            if (m_c > 0) m_c--;
            else begin m_up = 1; m_amp = int'(amp_in); m_c = (m_amp > 1) ? 1 : 0; end
         end
         if (ref_stb) m_ref = int'(ref_in);
      end
   end

   always @(negedge clk) begin : compare
      logic [5:0] got, exp_g;
      if (cmp_en && !rst) begin
         got   = {gate_pos, gate_neg, gate_xa, gate_xb, gate_ya, gate_yb};
         exp_g = {m_on[0] != 0 && m_side[0] != 0, m_on[0] != 0 && m_side[0] == 0,
                  m_on[1] != 0 && m_side[1] != 0, m_on[1] != 0 && m_side[1] == 0,
                  m_on[2] != 0 && m_side[2] != 0, m_on[2] != 0 && m_side[2] == 0};
         n_chk++;
         if (got !== exp_g || int'(region) != m_rg) begin
            n_fail++;
            if (int'(region) != m_rg)
               $display("FAIL R7 (%s) region=%0d expected=%0d", cur_req, region, m_rg);
            if (got !== exp_g)
               $display("FAIL %s R8/R9 gates=%b expected=%b", cur_req, got, exp_g);
         end
         n_chk++;
         if ((gate_pos && gate_neg) || (gate_xa && gate_xb) || (gate_ya && gate_yb)) begin
            n_fail++;
            $display("FAIL R10 overlap gates=%b expected no pair with 11", got);
         end
      end
   end

   task automatic hold(input string tag, input int r, input int a, input int d, input int n);
      cur_req = tag;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ref_in   = r[REF_W-1:0];
         amp_in   = a[AMP_W-1:0];
         dead_cyc = d[DT_W-1:0];
         ref_stb  = (k % 4 == 0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: run=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      rst = 1'b1; amp_in = 12'd20; dead_cyc = 6'd2;
      repeat (4) @(negedge clk);
      // R12: reset state
      n_chk++;
      if ({gate_pos, gate_neg, gate_xa, gate_xb, gate_ya, gate_yb} !== 6'b0) begin
         n_fail++;
         $display("FAIL R12 gates=%b expected=000000",
                  {gate_pos, gate_neg, gate_xa, gate_xb, gate_ya, gate_yb});
      end
      n_chk++;
      if (region !== 2'd0) begin
         n_fail++;
         $display("FAIL R12 region=%0d expected=0", region);
      end
      rst = 1'b0;
      cmp_en = 1;

      hold("R4 positive low", 7, 20, 2, 160);
      hold("R8 compare", 13, 20, 1, 120);
      hold("R4 positive high", 30, 20, 2, 160);
      hold("R5 negative low", -7, 20, 2, 160);
      hold("R5 negative high", -33, 20, 2, 160);
      hold("R3 clamp high", 32000, 20, 2, 120);
      hold("R3 clamp low", -32000, 20, 2, 120);
      hold("R3 exact 2A", 40, 20, 2, 120);
      hold("R3 exact -2A", -40, 20, 2, 120);
      hold("R7 at +A", 20, 20, 2, 120);
      hold("R7 at -A", -20, 20, 2, 120);
      hold("R9 zero", 0, 20, 2, 120);
      hold("R9 tiny positive", 1, 20, 2, 120);

      // R2: reference moves with no strobe, then strobed every cycle
      cur_req = "R2 no strobe";
      for (int k = 0; k < 120; k++) begin
         @(negedge clk);
         ref_in  = ((k % 2) != 0) ? 16'sd35 : -16'sd35;
         ref_stb = 1'b0;
      end
      cur_req = "R2 strobe every cycle";
      for (int k = 0; k < 120; k++) begin
         @(negedge clk);
         ref_in  = 16'(k * 7 - 400);
         ref_stb = 1'b1;
      end

      hold("R1 amp 9", 10, 9, 2, 120);
      hold("R1 amp 2", 3, 2, 1, 60);
      hold("R1 amp 1", -1, 1, 1, 60);
      hold("R1 amp 3", -4, 3, 1, 60);
      hold("R10 dead 0", 15, 20, 0, 160);
      hold("R10 dead 7", -25, 20, 7, 200);

      for (int r = -45; r <= 45; r += 3) hold("R6 sweep", r, 20, 1, 16);
      for (int r = 45; r >= -45; r -= 5) hold("R11 sweep", r, 16, 0, 20);

      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule